// File: doc/BRIEF.md
# Four-Channel Edge Capture Unit With Flag Register

This unit timestamps signal transitions against a counter that lives outside it. Each of up to four channels watches its own input pin. When the channel is armed and the pin changes level in either direction, the channel copies the counter value into its own holding register and raises its own flag. A separate overflow pulse from the counter raises an update flag. Software reads and clears the flags through a small register port. A mask register chooses which flags drive the single interrupt line.

Channels beyond the implemented count still have register fields, but those fields are tied to zero. Software can therefore find out how many channels exist by writing ones to the arm-enable register and counting the bits that read back as one. Flags are cleared by writing zero to them, so one flag can be cleared without disturbing the others.

Top module: `cap_top`

## Requirements
- R1: After reset, all four registers read 0, every captured value is 0 and `irq_o` is low.
- R2: Channel n captures only when its 2-bit mode field (bits 2n+1:2n of register 0) holds 01 and its enable bit (bit n of register 1) is 1. When both hold, a level change on `cap_in[n]` seen at a clock edge loads the `cnt_i` value present at that edge into slice n of `cap_flat`. Both rising and falling changes count.
- R3: A capture on channel n sets bit n+1 of the status register (register 2).
- R4: A channel whose mode field is not 01, or whose enable bit is 0, ignores its input: neither its captured value nor its flag changes.
- R5: A high `ovf_i` at a clock edge sets status bit 0.
- R6: A write to the status register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: A capture in the same cycle as a write that clears that channel's flag leaves the flag set.
- R8: `irq_o` is high exactly when some status bit in 0..4 is set and the same bit of the interrupt-enable register (register 3) is set.
- R9: A later capture overwrites the held value even if the flag is still set.
- R10: Enable, mode and interrupt-enable bits that belong to unimplemented channels read 0 after a write of ones, so the number of enable bits that stick equals the implemented channel count.
- R11: Register 0 (mode), register 1 (enable) and register 3 (interrupt enable) read back the last value written to their implemented bits, one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Shared counter value to capture |
| ovf_i | input | 1 | Counter overflow/underflow pulse |
| cap_in | input | NCH | Channel input pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mode, 1 enable, 2 status, 3 interrupt enable |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq_o | output | 1 | Combined interrupt |
| cap_flat | output | NCH*CNT_W | Captured values, channel n at bits n*CNT_W +: CNT_W |

## Verification
The checks assume that `cap_in` is low while reset is held, because the edge detector's previous-level register starts at zero. They also assume that inputs change only between clock edges. The stimulus keeps every pin low through reset and drives inputs on the falling edge. The counter input is held at a distinct value in each step, so that a captured value shows which step produced it. Overflow pulses last exactly one cycle, so the update-flag check sees a single set event.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_EN   = 2'd1,
        REG_STAT = 2'd2,
        REG_IE   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] MODE_OUT  = 2'b00;
    localparam logic [1:0] MODE_CAPT = 2'b01;
endpackage

// File: rtl/cap_chan.sv
`timescale 1ns/1ps
module cap_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             sig_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] val_o
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] val;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
        hit_o     = arm_i & (sig_i ^ st_q.prev);
        if (hit_o) begin
            st_d.val = cnt_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_o = st_q.val;
endmodule

// File: rtl/cap_flags.sv
`timescale 1ns/1ps
module cap_flags #(
    parameter int NCH     = 4,
    parameter int IMPL_CH = 4,
    localparam int SW     = NCH + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_i,
    input  logic          stat_we,
    input  logic          ie_we,
    input  logic [SW-1:0] wdata,
    output logic [SW-1:0] stat_o,
    output logic [SW-1:0] ie_o,
    output logic          irq_o
);
    localparam logic [SW-1:0] LIVE = SW'((1 << (IMPL_CH + 1)) - 1);

    typedef struct packed {
        logic [SW-1:0] stat;
        logic [SW-1:0] ie;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stat = (stat_we ? (st_q.stat & wdata) : st_q.stat) | set_i;
        if (ie_we) begin
            st_d.ie = wdata & LIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign ie_o   = st_q.ie;
    assign irq_o  = |(st_q.stat & st_q.ie);
endmodule

// File: rtl/cap_top.sv
`timescale 1ns/1ps
module cap_top #(
    parameter int NCH     = 4,
    parameter int IMPL_CH = 4,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cnt_i,
    input  logic                 ovf_i,
    input  logic [NCH-1:0]       cap_in,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq_o,
    output logic [NCH*CNT_W-1:0] cap_flat
);
    import cap_pkg::*;

    localparam int SW = NCH + 1;
    localparam int MW = 2 * NCH;
    localparam logic [NCH-1:0] EN_LIVE   = NCH'((1 << IMPL_CH) - 1);
    localparam logic [MW-1:0]  MODE_LIVE = MW'((1 << (2 * IMPL_CH)) - 1);

    typedef struct packed {
        logic [MW-1:0]  mode;
        logic [NCH-1:0] en;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic [NCH-1:0] hit;
    logic [SW-1:0]  stat;
    logic [SW-1:0]  ie;
    logic           wr_stat, wr_ie;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && addr == REG_MODE) begin
            cfg_d.mode = wdata[MW-1:0] & MODE_LIVE;
        end
        if (wr_en && addr == REG_EN) begin
            cfg_d.en = wdata[NCH-1:0] & EN_LIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g < IMPL_CH) begin : g_live
            logic arm;
            assign arm = (cfg_q.mode[2*g +: 2] == MODE_CAPT) & cfg_q.en[g];
            cap_chan #(.CNT_W(CNT_W)) u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .arm_i (arm),
                .sig_i (cap_in[g]),
                .cnt_i (cnt_i),
                .hit_o (hit[g]),
                .val_o (cap_flat[g*CNT_W +: CNT_W])
            );
        end else begin : g_dead
            assign hit[g] = 1'b0;
            assign cap_flat[g*CNT_W +: CNT_W] = '0;
        end
    end

    assign wr_stat = wr_en && (addr == REG_STAT);
    assign wr_ie   = wr_en && (addr == REG_IE);

    cap_flags #(.NCH(NCH), .IMPL_CH(IMPL_CH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   ({hit, ovf_i}),
        .stat_we (wr_stat),
        .ie_we   (wr_ie),
        .wdata   (wdata[SW-1:0]),
        .stat_o  (stat),
        .ie_o    (ie),
        .irq_o   (irq_o)
    );

    always_comb begin
        case (addr)
            REG_MODE: rdata = DATA_W'(cfg_q.mode);
            REG_EN:   rdata = DATA_W'(cfg_q.en);
            REG_STAT: rdata = DATA_W'(stat);
            default:  rdata = DATA_W'(ie);
        endcase
    end
endmodule

// File: rtl/cap_chk.sv
`timescale 1ns/1ps
module cap_chk #(
    parameter int NCH     = 4,
    parameter int IMPL_CH = 4,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ovf_i,
    input logic [CNT_W-1:0]     cnt_i,
    input logic [NCH-1:0]       hit,
    input logic [NCH:0]         stat,
    input logic [NCH:0]         ie,
    input logic                 irq_o,
    input logic [NCH*CNT_W-1:0] cap_flat,
    input logic [1:0]           addr,
    input logic [DATA_W-1:0]    rdata
);
    for (genvar g = 0; g < NCH; g++) begin : g_p
        // R2
        capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> cap_flat[g*CNT_W +: CNT_W] == $past(cnt_i));
        // R3 R7
        flag_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> stat[g+1]);
    end

    // R4
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |=> $stable(cap_flat));

    // R5
    update_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> stat[0]);

    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie == '0) |-> !irq_o);

    // R10
    dead_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd1) |-> (rdata[DATA_W-1:IMPL_CH] == '0));
endmodule

bind cap_top cap_chk #(
    .NCH(NCH), .IMPL_CH(IMPL_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf_i), .cnt_i(cnt_i), .hit(hit),
    .stat(stat), .ie(ie), .irq_o(irq_o), .cap_flat(cap_flat),
    .addr(addr), .rdata(rdata)
);

// File: tb/sim_cap_top.sv
`timescale 1ns/1ps
module sim_cap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic        ovf_i = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_o;
    logic [63:0] cap_flat;

    logic        w1 = 1'b0;
    logic [1:0]  a1 = '0;
    logic [15:0] d1 = '0;
    logic [15:0] r1;
    logic        irq1;
    logic [63:0] cap1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cap_top u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .ovf_i(ovf_i), .cap_in(cap_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq_o), .cap_flat(cap_flat)
    );

    cap_top #(.IMPL_CH(2)) u1 (
        .clk(clk), .rst_n(rst_n), .cnt_i(16'h0), .ovf_i(1'b0), .cap_in(4'h0),
        .wr_en(w1), .addr(a1), .wdata(d1), .rdata(r1),
        .irq_o(irq1), .cap_flat(cap1)
    );

    typedef struct packed {
        bit        we;
        bit [1:0]  a;
        bit [15:0] d;
        bit [3:0]  s;
        bit        ov;
        bit [15:0] c;
        bit [1:0]  ca;
        bit [15:0] ex;
        bit        irq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 16'h0055, 4'h0, 1'b0, 16'h0000, 2'd0, 16'h0055, 1'b0}, // R11 mode
        '{1'b1, 2'd1, 16'h000F, 4'h0, 1'b0, 16'h0000, 2'd1, 16'h000F, 1'b0}, // R11 enable
        '{1'b1, 2'd3, 16'h001F, 4'h0, 1'b0, 16'h0000, 2'd3, 16'h001F, 1'b0}, // R11 ie
        '{1'b0, 2'd0, 16'h0000, 4'h1, 1'b0, 16'h1234, 2'd2, 16'h0002, 1'b1}, // R3 rise ch0
        '{1'b0, 2'd0, 16'h0000, 4'h0, 1'b0, 16'h2000, 2'd2, 16'h0002, 1'b1}, // R9 fall ch0
        '{1'b0, 2'd0, 16'h0000, 4'h0, 1'b1, 16'h0000, 2'd2, 16'h0003, 1'b1}, // R5
        '{1'b1, 2'd2, 16'hFFFD, 4'h0, 1'b0, 16'h0000, 2'd2, 16'h0001, 1'b1}, // R6
        '{1'b1, 2'd2, 16'hFFFE, 4'h0, 1'b0, 16'h0000, 2'd2, 16'h0000, 1'b0}, // R6
        '{1'b1, 2'd3, 16'h0000, 4'h6, 1'b0, 16'h3333, 2'd2, 16'h000C, 1'b0}, // R8 masked
        '{1'b1, 2'd3, 16'h0008, 4'h6, 1'b0, 16'h0000, 2'd2, 16'h000C, 1'b1}, // R8 one bit
        '{1'b1, 2'd3, 16'h0002, 4'h6, 1'b0, 16'h0000, 2'd3, 16'h0002, 1'b0}, // R8 other bit
        '{1'b1, 2'd2, 16'h0000, 4'hE, 1'b0, 16'h4444, 2'd2, 16'h0010, 1'b0}, // R7
        '{1'b1, 2'd1, 16'h0000, 4'hE, 1'b0, 16'h0000, 2'd1, 16'h0000, 1'b0}, // R11 disable
        '{1'b0, 2'd0, 16'h0000, 4'h0, 1'b0, 16'h5555, 2'd2, 16'h0010, 1'b0}  // R4 disabled
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input bit we, input bit [1:0] a, input bit [15:0] d,
                         input bit [3:0] s, input bit ov, input bit [15:0] c);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; cap_in = s; ovf_i = ov; cnt_i = c;
        @(negedge clk);
        wr_en = 1'b0; ovf_i = 1'b0;
    endtask

    task automatic wr1(input bit [1:0] a, input bit [15:0] d);
        @(negedge clk);
        w1 = 1'b1; a1 = a; d1 = d;
        @(negedge clk);
        w1 = 1'b0;
        #1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            addr = 2'(k);
            #1;
            chk("R1 register", rdata, 16'h0);
        end
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 captures", cap_flat[31:0], 32'h0);
        chk("R1 captures hi", cap_flat[63:32], 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].we, TBL[i].a, TBL[i].d, TBL[i].s, TBL[i].ov, TBL[i].c);
            addr = TBL[i].ca;
            #1;
            chk($sformatf("vector %0d register", i), rdata, TBL[i].ex);
            chk($sformatf("vector %0d irq", i), irq_o, TBL[i].irq);
        end

        // R2 R9 captured values after the table
        chk("R9 ch0 overwritten", cap_flat[15:0], 16'h2000);
        chk("R2 ch1", cap_flat[31:16], 16'h3333);
        chk("R2 ch2", cap_flat[47:32], 16'h3333);
        chk("R2 ch3", cap_flat[63:48], 16'h4444);

        // R4 mode field not capture, enable set
        drive(1'b1, 2'd2, 16'h0000, 4'h0, 1'b0, 16'h0);
        drive(1'b1, 2'd0, 16'h0002, 4'h0, 1'b0, 16'h0);
        drive(1'b1, 2'd1, 16'h000F, 4'h0, 1'b0, 16'h0);
        drive(1'b0, 2'd0, 16'h0000, 4'h1, 1'b0, 16'h7777);
        addr = 2'd2;
        #1;
        chk("R4 no flag", rdata, 16'h0000);
        chk("R4 value held", cap_flat[15:0], 16'h2000);

        // R2 armed again, falling edge captures
        drive(1'b1, 2'd0, 16'h0001, 4'h1, 1'b0, 16'h0);
        drive(1'b0, 2'd0, 16'h0000, 4'h0, 1'b0, 16'h6666);
        addr = 2'd2;
        #1;
        chk("R2 flag", rdata, 16'h0002);
        chk("R2 value", cap_flat[15:0], 16'h6666);

        // R10 channel count detection on a two-channel build
        wr1(2'd1, 16'hFFFF);
        a1 = 2'd1;
        #1;
        chk("R10 enable bits", r1, 16'h0003);
        chk("R10 count", $countones(r1), 2);
        wr1(2'd0, 16'hFFFF);
        a1 = 2'd0;
        #1;
        chk("R10 mode bits", r1, 16'h000F);
        wr1(2'd3, 16'hFFFF);
        a1 = 2'd3;
        #1;
        chk("R10 ie bits", r1, 16'h0007);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule